// File: doc/BRIEF.md
# Category-Encoded Integer Core

This block is a single-cycle integer processor for a reduced load/store instruction set. Each 32-bit instruction word holds a 2-bit category in bits [1:0] and a 5-bit operation code in bits [6:2]. Bits [31:7] hold the register numbers and immediates in the usual R/I/S/J field positions. Every clock cycle the core fetches the word at its program counter, executes it completely and moves to the next address. The supported operations are word loads and stores, register-register and register-immediate arithmetic and logic, immediate shifts, three conditional branches and a linking jump.

The instruction memory is read through a combinational port: the `pc` output is the fetch address and the word comes back on `instr` in the same cycle. The data memory works the same way for reads, and a store is a one-cycle write strobe with address and data. After reset, execution starts at byte address 256 and every register reads zero. The stop instruction freezes the core. The `retire` output pulses once for every instruction that executes, so an external reference model can follow the core step by step.

Top module: `rvx_core`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `pc` is 256, `halted` is 0, `dmem_we` is 0, and every register x0..x31 reads as zero.
- R2: Bits [1:0] select the category: 00 for the branches and the store, 01 for the register-register ops, 10 for the immediate ops and the load, 11 for the jump and the stop. Bits [6:2] select the operation within the category. An unlisted code acts as a no-op that advances `pc` by 4.
- R3: Category 01 codes 0,1,2,3 write rd with rs1+rs2, rs1-rs2, rs1&rs2 and rs1|rs2, taken modulo 2^32. rd is bits [11:7], rs1 is bits [19:15] and rs2 is bits [24:20].
- R4: Category 10 codes 0,1,2 write rd with rs1+imm, rs1&imm and rs1|imm. The immediate is bits [31:20], sign-extended.
- R5: Category 10 code 3 shifts rs1 left and code 4 shifts rs1 right arithmetically. The shift amount is immediate bits [4:0] (instruction bits [24:20]), and the upper immediate bits are ignored.
- R6: Category 10 code 5 loads the data word at rs1+sext(bits[31:20]) into rd. Category 00 code 3 raises `dmem_we` for one cycle, with `dmem_addr` = rs1+sext({bits[31:25],bits[11:7]}) and `dmem_wdata` = rs2.
- R7: Category 00 codes 0,1,2 compare rs1 with rs2 for equal, not equal and signed less-than. When the compare is true, the next `pc` is the branch's own address plus sext({bits[31:25],bits[11:7]})<<1. Otherwise it is the address plus 4. There is no delay slot.
- R8: Category 11 code 0 writes its address+4 into rd and jumps to its address plus sext({b31,b19..b12,b20,b30..b21,0}).
- R9: A write whose destination is x0 is discarded, and x0 always reads zero.
- R10: Category 11 code 31 sets `halted` on the next edge. From then on `pc` stays at the stop instruction's address, no store happens and no register changes until reset.
- R11: `retire` is high in every cycle in which an instruction executes (reset released, not halted), including the cycle of the stop instruction, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc | output | 32 | Current instruction byte address, used as the fetch address |
| instr | input | 32 | Instruction word at `pc`, same cycle |
| dmem_addr | output | 32 | Data byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |
| retire | output | 1 | One instruction executes in this cycle |
| halted | output | 1 | Core is stopped after the stop instruction |

## Verification
The main function is tried with three kinds of programs. Directed arithmetic sequences push sums past the signed limit, use negative immediates in the logic ops, and set shift immediates with upper bits, so that wrap-around, sign extension and shift-field masking are each checked on their own. A control-flow program separates a signed from an unsigned less-than, takes branches forwards and backwards, leaves one untaken, and checks jump linking. Random programs mix every category, including writes to x0 and short forward branches, and compare each step's fetch address and store against a bench model, then compare the final data image.

// File: rtl/rvx_pkg.sv
package rvx_pkg;
   localparam int WORD_W = 32;
   localparam int OPC_W  = 5;

   typedef enum logic [1:0] {
      CAT_BRST = 2'b00,
      CAT_REG  = 2'b01,
      CAT_IMM  = 2'b10,
      CAT_CTL  = 2'b11
   } cat_e;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_SUB = 3'd1,
      ALU_AND = 3'd2,
      ALU_OR  = 3'd3,
      ALU_SLL = 3'd4,
      ALU_SRA = 3'd5
   } alu_e;

   typedef enum logic [1:0] {
      CMP_NONE = 2'd0,
      CMP_EQ   = 2'd1,
      CMP_NE   = 2'd2,
      CMP_LT   = 2'd3
   } cmp_e;

   typedef struct packed {
      logic [4:0]        rd;
      logic [4:0]        rs1;
      logic [4:0]        rs2;
      logic [WORD_W-1:0] imm_op;
      logic [WORD_W-1:0] imm_br;
      logic [WORD_W-1:0] imm_j;
      alu_e              alu;
      cmp_e              cmp;
      logic              use_imm;
      logic              wr_en;
      logic              ld;
      logic              st;
      logic              jal;
      logic              brk;
   } ctrl_t;
endpackage

// File: rtl/rvx_decode.sv
module rvx_decode
   import rvx_pkg::*;
(
   input  logic [WORD_W-1:0] instr,
   output ctrl_t             ctl
);
   logic [OPC_W-1:0]  opc;
   logic [WORD_W-1:0] imm_i, imm_s;

   assign opc   = instr[6:2];
   assign imm_i = {{20{instr[31]}}, instr[31:20]};
   assign imm_s = {{20{instr[31]}}, instr[31:25], instr[11:7]};

   always_comb begin
      ctl         = '0;
      ctl.rd      = instr[11:7];
      ctl.rs1     = instr[19:15];
      ctl.rs2     = instr[24:20];
      ctl.imm_br  = {imm_s[WORD_W-2:0], 1'b0};
      ctl.imm_j   = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
      ctl.imm_op  = imm_i;
      ctl.alu     = ALU_ADD;
      ctl.cmp     = CMP_NONE;
      case (cat_e'(instr[1:0]))
         CAT_BRST: begin
            case (opc)
               5'd0: ctl.cmp = CMP_EQ;
               5'd1: ctl.cmp = CMP_NE;
               5'd2: ctl.cmp = CMP_LT;
               5'd3: begin
                  ctl.st      = 1'b1;
                  ctl.use_imm = 1'b1;
                  ctl.imm_op  = imm_s;
               end
               default: ;
            endcase
         end
         CAT_REG: begin
            ctl.wr_en = (opc < 5'd4);
            case (opc)
               5'd1:    ctl.alu = ALU_SUB;
               5'd2:    ctl.alu = ALU_AND;
               5'd3:    ctl.alu = ALU_OR;
               default: ctl.alu = ALU_ADD;
            endcase
         end
         CAT_IMM: begin
            ctl.use_imm = 1'b1;
            ctl.wr_en   = (opc < 5'd6);
            ctl.ld      = (opc == 5'd5);
            case (opc)
               5'd1:    ctl.alu = ALU_AND;
               5'd2:    ctl.alu = ALU_OR;
               5'd3:    ctl.alu = ALU_SLL;
               5'd4:    ctl.alu = ALU_SRA;
               default: ctl.alu = ALU_ADD;
            endcase
         end
         default: begin
            ctl.jal   = (opc == 5'd0);
            ctl.wr_en = (opc == 5'd0);
            ctl.brk   = (opc == 5'd31);
         end
      endcase
   end
endmodule

// File: rtl/rvx_alu.sv
module rvx_alu
   import rvx_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_e            op,
   output logic [XLEN-1:0] y
);
   localparam int SHW = $clog2(XLEN);
   logic [SHW-1:0] shamt;

   assign shamt = b[SHW-1:0];

   always_comb begin
      case (op)
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLL: y = a << shamt;
         ALU_SRA: y = $signed(a) >>> shamt;
         default: y = a + b;
      endcase
   end
endmodule

// File: rtl/rvx_regfile.sv
module rvx_regfile #(
   parameter int XLEN  = 32,
   parameter int NREGS = 32,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   ra_addr,
   output logic [XLEN-1:0] ra_data,
   input  logic [AW-1:0]   rb_addr,
   output logic [XLEN-1:0] rb_data,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [XLEN-1:0] wr_data
);
   logic [NREGS*XLEN-1:0] flat;

   assign flat[XLEN-1:0] = '0;

   for (genvar i = 1; i < NREGS; i++) begin : g_reg
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && wr_addr == AW'(i))
            q <= wr_data;
      end
      assign flat[i*XLEN +: XLEN] = q;
   end

   assign ra_data = flat[ra_addr*XLEN +: XLEN];
   assign rb_data = flat[rb_addr*XLEN +: XLEN];
endmodule

// File: rtl/rvx_core.sv
module rvx_core
   import rvx_pkg::*;
#(
   parameter int          XLEN     = 32,
   parameter int          NREGS    = 32,
   parameter logic [31:0] RESET_PC = 32'd256
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [XLEN-1:0] pc,
   input  logic [31:0]     instr,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   input  logic [XLEN-1:0] dmem_rdata,
   output logic            retire,
   output logic            halted
);
   localparam int RAW = $clog2(NREGS);

   if (XLEN != WORD_W) begin : g_bad_xlen
      $error("rvx_core: XLEN must equal the package word width");
   end
   if (NREGS != 32) begin : g_bad_nregs
      $error("rvx_core: the 5-bit register fields need NREGS of 32");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_pc
      $error("rvx_core: RESET_PC must be word aligned");
   end

   ctrl_t           ctl;
   logic [XLEN-1:0] rs1_v, rs2_v, alu_b, alu_y, wb_v;
   logic [XLEN-1:0] pc_seq, pc_br, pc_jmp, pc_nxt;
   logic            live, take;

   rvx_decode u_dec (
      .instr (instr),
      .ctl   (ctl)
   );

   rvx_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_addr (ctl.rs1[RAW-1:0]),
      .ra_data (rs1_v),
      .rb_addr (ctl.rs2[RAW-1:0]),
      .rb_data (rs2_v),
      .wr_en   (live && ctl.wr_en),
      .wr_addr (ctl.rd[RAW-1:0]),
      .wr_data (wb_v)
   );

   assign alu_b = ctl.use_imm ? ctl.imm_op : rs2_v;

   rvx_alu #(.XLEN(XLEN)) u_alu (
      .a  (rs1_v),
      .b  (alu_b),
      .op (ctl.alu),
      .y  (alu_y)
   );

   assign live   = rst_n && !halted;
   assign pc_seq = pc + XLEN'(4);
   assign pc_br  = pc + ctl.imm_br;
   assign pc_jmp = pc + ctl.imm_j;

   always_comb begin
      case (ctl.cmp)
         CMP_EQ:  take = (rs1_v == rs2_v);
         CMP_NE:  take = (rs1_v != rs2_v);
         CMP_LT:  take = ($signed(rs1_v) < $signed(rs2_v));
         default: take = 1'b0;
      endcase
   end

   always_comb begin
      if (ctl.brk)      pc_nxt = pc;
      else if (ctl.jal) pc_nxt = pc_jmp;
      else if (take)    pc_nxt = pc_br;
      else              pc_nxt = pc_seq;
   end

   assign wb_v = ctl.ld ? dmem_rdata : (ctl.jal ? pc_seq : alu_y);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc     <= RESET_PC;
         halted <= 1'b0;
      end else if (!halted) begin
         pc     <= pc_nxt;
         halted <= ctl.brk;
      end
   end

   assign dmem_addr  = alu_y;
   assign dmem_wdata = rs2_v;
   assign dmem_we    = live && ctl.st;
   assign retire     = live;

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R10
   AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(pc)); // R10
   AST_HALT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !dmem_we); // R10
   AST_BRK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && ctl.brk) |=> halted); // R10
   AST_RETIRE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !retire); // R11
   AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && ctl.cmp == CMP_NONE && !ctl.jal && !ctl.brk)
      |=> (pc == $past(pc) + XLEN'(4))); // R7
   AST_SRA_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && ctl.alu == ALU_SRA && rs1_v[XLEN-1]) |-> alu_y[XLEN-1]); // R5
endmodule

// File: tb/rvx_core_test.sv
module rvx_core_test;
   localparam int CLK_PERIOD = 10;
   localparam int IM_WORDS   = 128;
   localparam int PROG_LIMIT = 4000;
   localparam logic [31:0] BRK = {25'd0, 5'd31, 2'b11};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc, instr, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we, retire, halted;

   logic [31:0] im [IM_WORDS];
   logic [31:0] dm [256];
   logic [31:0] ref_dm [256];
   logic [31:0] ref_rf [32];
   logic [31:0] ref_pc;
   logic        ref_halted;
   int          checks = 0;
   int          errors = 0;
   int          plen = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rvx_core uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pc         (pc),
      .instr      (instr),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata),
      .retire     (retire),
      .halted     (halted)
   );

   function automatic logic [31:0] fetch(input logic [31:0] a);
      logic [31:0] idx;
      idx = (a - 32'd256) >> 2;
      if (a < 32'd256 || idx >= IM_WORDS) return BRK;
      return im[idx];
   endfunction

   assign instr      = fetch(pc);
   assign dmem_rdata = dm[dmem_addr[9:2]];

   always @(posedge clk) if (dmem_we) dm[dmem_addr[9:2]] <= dmem_wdata;

   function automatic logic [31:0] enc_r(input int op, input int rd, input int rs1, input int rs2);
      return {7'd0, 5'(rs2), 5'(rs1), 3'd0, 5'(rd), 5'(op), 2'b01};
   endfunction
   function automatic logic [31:0] enc_i(input int op, input int rd, input int rs1, input logic [11:0] im12);
      return {im12, 5'(rs1), 3'd0, 5'(rd), 5'(op), 2'b10};
   endfunction
   function automatic logic [31:0] enc_s(input int op, input int rs1, input int rs2, input logic [11:0] f);
      return {f[11:5], 5'(rs2), 5'(rs1), 3'd0, f[4:0], 5'(op), 2'b00};
   endfunction
   function automatic logic [31:0] enc_j(input int rd, input logic [20:0] o);
      return {o[20], o[10:1], o[11], o[19:12], 5'(rd), 5'd0, 2'b11};
   endfunction

   task automatic emit(input logic [31:0] w);
      im[plen] = w;
      plen++;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic clear_prog();
      for (int i = 0; i < IM_WORDS; i++) im[i] = BRK;
      plen = 0;
      for (int i = 0; i < 256; i++) begin
         dm[i]     = (i < 64) ? $urandom : 32'd0;
         ref_dm[i] = dm[i];
      end
   endtask

   task automatic ref_step(output string tag, output bit sw,
                           output logic [31:0] sa, output logic [31:0] sd);
      logic [31:0] w, a, b, ii, is, jj, npc, v;
      logic [4:0]  op, rd;
      bit          wen;
      w  = fetch(ref_pc);
      op = w[6:2];
      rd = w[11:7];
      a  = ref_rf[w[19:15]];
      b  = ref_rf[w[24:20]];
      ii = {{20{w[31]}}, w[31:20]};
      is = {{20{w[31]}}, w[31:25], w[11:7]};
      jj = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
      npc = ref_pc + 32'd4;
      wen = 1'b0; v = '0; sw = 1'b0; sa = '0; sd = '0;
      tag = "R2";
      case (w[1:0])
         2'b00: begin
            tag = "R7";
            if (op == 5'd0 && a == b) npc = ref_pc + (is << 1);
            if (op == 5'd1 && a != b) npc = ref_pc + (is << 1);
            if (op == 5'd2 && $signed(a) < $signed(b)) npc = ref_pc + (is << 1);
            if (op == 5'd3) begin
               tag = "R6"; sw = 1'b1; sa = a + is; sd = b;
            end
         end
         2'b01: if (op < 5'd4) begin
            tag = "R3"; wen = 1'b1;
            case (op)
               5'd0: v = a + b;
               5'd1: v = a - b;
               5'd2: v = a & b;
               default: v = a | b;
            endcase
         end
         2'b10: if (op < 5'd6) begin
            tag = "R4"; wen = 1'b1;
            case (op)
               5'd0: v = a + ii;
               5'd1: v = a & ii;
               5'd2: v = a | ii;
               5'd3: begin tag = "R5"; v = a << ii[4:0]; end
               5'd4: begin tag = "R5"; v = $signed(a) >>> ii[4:0]; end
               default: begin
                  tag = "R6"; v = ref_dm[(a + ii) >> 2 & 32'd255];
               end
            endcase
         end
         default: begin
            if (op == 5'd0) begin
               tag = "R8"; wen = 1'b1; v = ref_pc + 32'd4; npc = ref_pc + jj;
            end else if (op == 5'd31) begin
               tag = "R10"; ref_halted = 1'b1; npc = ref_pc;
            end
         end
      endcase
      if (wen && rd != 5'd0) ref_rf[rd] = v;
      if (sw) ref_dm[sa[9:2]] = sd;
      ref_pc = npc;
   endtask

   task automatic run_prog();
      string       tag;
      bit          sw;
      logic [31:0] sa, sd;
      int          cyc = 0;
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 32; i++) ref_rf[i] = '0;
      ref_pc = 32'd256;
      ref_halted = 1'b0;
      #1;
      chk(pc == 32'd256, "R1", "pc in reset", pc, 32'd256);
      chk(!halted && !dmem_we && !retire, "R1", "flags in reset",
          {halted, dmem_we, retire}, 32'd0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      while (!ref_halted && cyc < PROG_LIMIT) begin
         chk(pc == ref_pc, "R7", "fetch address", pc, ref_pc);
         chk(retire == 1'b1, "R11", "retire while running", retire, 32'd1);
         ref_step(tag, sw, sa, sd);
         chk(dmem_we == sw, tag, "store strobe", dmem_we, sw);
         if (sw) begin
            chk(dmem_addr == sa, "R6", "store address", dmem_addr, sa);
            chk(dmem_wdata == sd, "R6", "store data", dmem_wdata, sd);
         end
         cyc++;
         @(negedge clk);
         #1;
      end
      chk(cyc < PROG_LIMIT, "R10", "program reached stop", cyc, PROG_LIMIT);
      for (int k = 0; k < 4; k++) begin
         chk(halted == 1'b1, "R10", "halted stays", halted, 32'd1);
         chk(pc == ref_pc, "R10", "pc frozen", pc, ref_pc);
         chk(!retire && !dmem_we, "R11", "no activity when halted",
             {retire, dmem_we}, 32'd0);
         @(negedge clk);
         #1;
      end
      for (int i = 0; i < 256; i++)
         if (dm[i] !== ref_dm[i])
            chk(1'b0, "R3 R4 R5 R9", $sformatf("data word %0d", i), dm[i], ref_dm[i]);
      checks++;
   endtask

   task automatic rand_prog();
      clear_prog();
      for (int n = 0; n < 60; n++) begin
         int k, rd, r1, r2;
         k  = $urandom % 10;
         rd = $urandom % 8;
         r1 = $urandom % 8;
         r2 = $urandom % 8;
         if (k < 4)      emit(enc_r($urandom % 4, rd, r1, r2));
         else if (k < 7) emit(enc_i($urandom % 5, rd, r1, 12'($urandom)));
         else if (k == 7) emit(enc_i(5, rd, 0, 12'(($urandom % 64) * 4)));
         else if (k == 8) emit(enc_s(3, 0, r2, 12'(($urandom % 64) * 4)));
         else            emit(enc_s($urandom % 3, r1, r2, 12'd4));
      end
      for (int r = 0; r < 8; r++) emit(enc_s(3, 0, r, 12'((200 + r) * 4)));
      emit(BRK);
      run_prog();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog expired act=%0d exp=%0d", checks, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20231));

      // Directed arithmetic: R1 R3 R4 R5 R9
      clear_prog();
      emit(enc_s(3, 0, 5, 12'd400));          // x5 before any write: R1
      emit(enc_i(0, 1, 0, 12'd1));
      emit(enc_i(3, 1, 1, 12'd31));           // x1 = 0x80000000
      emit(enc_i(0, 2, 1, 12'hfff));          // x2 = 0x7fffffff
      emit(enc_i(0, 4, 0, 12'd1));
      emit(enc_r(0, 3, 2, 4));                // wraps to 0x80000000
      emit(enc_r(1, 5, 0, 4));                // -1
      emit(enc_r(2, 6, 5, 2));
      emit(enc_r(3, 7, 1, 4));
      emit(enc_i(4, 8, 1, 12'd4));            // 0xf8000000
      emit(enc_i(3, 9, 4, 12'd5));            // 32
      emit(enc_i(4, 10, 9, 12'h021));         // upper shift bit ignored: 16
      emit(enc_i(1, 11, 5, 12'hff0));
      emit(enc_i(2, 12, 0, 12'h800));
      emit(enc_i(0, 0, 4, 12'd5));            // x0 write: R9
      emit(enc_r(0, 0, 4, 4));
      for (int r = 0; r < 13; r++) emit(enc_s(3, 0, r, 12'((101 + r) * 4)));
      emit(BRK);
      run_prog();
      chk(dm[100] == 32'd0, "R1", "register zero after reset", dm[100], 32'd0);
      chk(dm[101] == 32'd0, "R9", "x0 after writes", dm[101], 32'd0);
      chk(dm[104] == 32'h80000000, "R3", "signed wrap add", dm[104], 32'h80000000);
      chk(dm[109] == 32'hf8000000, "R5", "arithmetic right shift", dm[109], 32'hf8000000);
      chk(dm[111] == 32'd16, "R5", "shift field masked", dm[111], 32'd16);
      chk(dm[112] == 32'hfffffff0, "R4", "andi sign extension", dm[112], 32'hfffffff0);
      chk(dm[113] == 32'hfffff800, "R4", "ori negative imm", dm[113], 32'hfffff800);

      // Control flow and memory: R6 R7 R8 R10
      clear_prog();
      dm[10] = 32'hfffffffb; ref_dm[10] = 32'hfffffffb;
      emit(enc_i(5, 1, 0, 12'd40));           // 256 lw x1 = -5
      emit(enc_i(0, 2, 0, 12'd3));            // 260
      emit(enc_s(2, 1, 2, 12'd4));            // 264 blt taken (signed)
      emit(enc_i(0, 3, 0, 12'd99));           // 268 skipped
      emit(enc_s(1, 1, 1, 12'd4));            // 272 bne not taken
      emit(enc_i(0, 4, 0, 12'd7));            // 276
      emit(enc_i(0, 5, 5, 12'd1));            // 280 loop
      emit(enc_s(1, 5, 2, 12'hffe));          // 284 back to 280
      emit(enc_s(0, 5, 2, 12'd4));            // 288 beq taken
      emit(enc_i(0, 6, 0, 12'd1));            // 292 skipped
      emit(enc_j(7, 21'd12));                 // 296 -> 308, x7 = 300
      emit(enc_i(0, 8, 0, 12'd1));            // 300 skipped
      emit(enc_i(0, 8, 0, 12'd2));            // 304 skipped
      emit(enc_s(3, 0, 7, 12'd128));          // 308 word 32
      emit(enc_s(3, 0, 1, 12'd132));
      emit(enc_s(3, 0, 3, 12'd136));
      emit(enc_s(3, 0, 5, 12'd140));
      emit(enc_s(3, 0, 6, 12'd144));
      emit(enc_s(3, 0, 4, 12'd148));
      emit(BRK);
      run_prog();
      chk(dm[32] == 32'd300, "R8", "jump link value", dm[32], 32'd300);
      chk(dm[33] == 32'hfffffffb, "R6", "loaded word", dm[33], 32'hfffffffb);
      chk(dm[34] == 32'd0, "R7", "taken branch skips next", dm[34], 32'd0);
      chk(dm[35] == 32'd3, "R7", "backward loop count", dm[35], 32'd3);
      chk(dm[36] == 32'd0, "R7", "beq skip", dm[36], 32'd0);
      chk(dm[37] == 32'd7, "R7", "untaken path runs", dm[37], 32'd7);
      chk(ref_pc == 32'd332, "R10", "stop address", ref_pc, 32'd332);

      // Unlisted codes act as no-ops: R2
      clear_prog();
      emit(enc_i(0, 1, 0, 12'd9));
      emit({25'd0, 5'd7, 2'b01});
      emit({25'd0, 5'd9, 2'b10});
      emit({20'd0, 5'd1, 5'd4, 2'b11});
      emit(enc_s(3, 0, 1, 12'd0));
      emit(BRK);
      run_prog();
      chk(dm[0] == 32'd9, "R2", "no-op codes leave x1", dm[0], 32'd9);

      for (int t = 0; t < 6; t++) rand_prog();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule